// File: doc/BRIEF.md
# Random Word Output Buffer

This block gathers a stream of conditioned random bits into a 128-bit block, split into four 32-bit words, and hands each finished block to software through a small memory-mapped register file. Each bit arrives on a one-bit input with a valid strobe. Once a full block has been gathered and a programmable minimum number of cycles has passed, the block raises a ready flag. It then freezes the words until software acknowledges them.

Software polls the ready flag and reads the four words. It then writes one to the ready bit. That write both clears the flag and starts gathering the next block. A programmable maximum cycle count marks a refill as slow: the block does not abandon the refill, but it records the overrun in a sticky status bit. A control register gates the whole process, and a constant revision register identifies the design build.

Top module: `rand_word_buf`

## Requirements
- R1: The data words read at offsets 0x00, 0x04, 0x08 and 0x0C. Each accepted bit shifts into bit 0 of a 128-bit gather register. Word k is bits [32k+31:32k] of that register, so the first bit of a block ends at bit 31 of the word at 0x0C. The same 128 bits appear on `words_o`.
- R2: Status at offset 0x10 holds ready in bit 0 and timeout in bit 1. Writing 1 to bit 0 clears ready and restarts gathering from zero bits and zero cycles. Writing 0 to bit 0 leaves ready unchanged.
- R3: Control at offset 0x14 holds the enable in bit 10 and reads all other bits as 0. While the enable is 0, incoming bits are ignored, partial progress is discarded and ready never rises.
- R4: After a restart, ready rises on the clock edge after the 128th accepted bit has been registered, provided the refill cycle count has reached the minimum. Otherwise ready rises on the edge after the count reaches the minimum.
- R5: Config at offset 0x18 holds the maximum refill cycles in [31:16] and the minimum in [7:0]. Other bits read 0. The reset values are maximum 0xFFFF and minimum 0.
- R6: While ready is set, `words_o` and the data registers do not change, and incoming bits are ignored.
- R7: If the refill cycle count reaches the maximum before 128 bits have arrived, status bit 1 becomes 1 and stays 1. Gathering continues to completion. Writing 1 to status bit 1 clears the timeout bit.
- R8: Offset 0x7C reads a constant revision word, with the major number in [27:24], the minor number in [23:20] and the patch level in [19:16]. With the default parameters it reads 0x02310000. Unmapped offsets read 0. Writes to read-only offsets have no effect.
- R9: After reset, ready, timeout, the enable and all data words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rnd_bit_vld | input | 1 | A random bit is present this cycle |
| rnd_bit | input | 1 | Random bit value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| words_o | output | 128 | Frozen block of data words, word 0 in [31:0] |
| ready_o | output | 1 | A full block is waiting to be acknowledged |

## Verification
The bench drives three bit streams from a bench-side LFSR. A back-to-back stream shows the plain bit-count path. A stream with one idle cycle between bits separates the counting of accepted bits from the counting of cycles, and with a small maximum it exercises the timeout while still finishing the block. A large minimum with back-to-back bits shows that the cycle floor, not the bit count, decides when ready rises. Extra bits during ready and a whole stream while disabled must leave no trace in the words of the next block.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_CTRL   = 8'h14;
  localparam logic [7:0] OFS_CFG    = 8'h18;
  localparam logic [7:0] OFS_REV    = 8'h7C;

  localparam int unsigned ST_READY_BIT = 0;
  localparam int unsigned ST_TMO_BIT   = 1;
  localparam int unsigned CTRL_EN_BIT  = 10;

  typedef struct packed {
    logic        enable;
    logic [15:0] max_cyc;
    logic [7:0]  min_cyc;
  } rwb_cfg_t;

  function automatic logic [31:0] rev_word(input logic [3:0] maj,
                                           input logic [3:0] mnr,
                                           input logic [3:0] pat);
    return {4'h0, maj, mnr, pat, 16'h0000};
  endfunction

  function automatic logic [31:0] cfg_word(input logic [15:0] mx,
                                           input logic [7:0]  mn);
    return {mx, 8'h00, mn};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic en);
    return {21'h0, en, 10'h000};
  endfunction

  function automatic logic [31:0] status_word(input logic rdy, input logic tmo);
    return {30'h0, tmo, rdy};
  endfunction

  // saturating refill cycle counter step
  function automatic logic [15:0] cyc_next(input logic [15:0] c);
    return (c == 16'hFFFF) ? c : c + 16'd1;
  endfunction

  function automatic logic min_met(input logic [15:0] c, input logic [7:0] mn);
    return c >= {8'h00, mn};
  endfunction

  function automatic logic max_reached(input logic [15:0] c, input logic [15:0] mx);
    return c >= mx;
  endfunction

endpackage

// File: rtl/rwb_csr.sv
module rwb_csr
  import rwb_pkg::*;
#(
  parameter logic [15:0] MAX_RST = 16'hFFFF,
  parameter logic [7:0]  MIN_RST = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output rwb_cfg_t    cfg_o,
  output logic        ack_ready_o,
  output logic        clr_tmo_o
);

  logic wr_ctrl, wr_cfg, wr_status;

  assign wr_ctrl   = wr_i && (addr_i == OFS_CTRL);
  assign wr_cfg    = wr_i && (addr_i == OFS_CFG);
  assign wr_status = wr_i && (addr_i == OFS_STATUS);

  assign ack_ready_o = wr_status && wdata_i[ST_READY_BIT];
  assign clr_tmo_o   = wr_status && wdata_i[ST_TMO_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o.enable  <= 1'b0;
      cfg_o.max_cyc <= MAX_RST;
      cfg_o.min_cyc <= MIN_RST;
    end else begin
      if (wr_ctrl) cfg_o.enable <= wdata_i[CTRL_EN_BIT];
      if (wr_cfg) begin
        cfg_o.max_cyc <= wdata_i[31:16];
        cfg_o.min_cyc <= wdata_i[7:0];
      end
    end
  end

endmodule

// File: rtl/rwb_gather.sv
module rwb_gather
  import rwb_pkg::*;
#(
  parameter int unsigned TOTAL_BITS = 128,
  localparam int unsigned CNT_W = $clog2(TOTAL_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable_i,
  input  logic                  restart_i,
  input  logic                  clr_tmo_i,
  input  logic [15:0]           max_cyc_i,
  input  logic [7:0]            min_cyc_i,
  input  logic                  bit_vld_i,
  input  logic                  bit_i,
  output logic [TOTAL_BITS-1:0] words_o,
  output logic                  ready_o,
  output logic                  tmo_o,
  output logic                  fill_active_o,
  output logic                  fill_done_o,
  output logic                  tmo_hit_o,
  output logic [CNT_W-1:0]      bit_cnt_o,
  output logic [15:0]           cyc_cnt_o
);

  logic [TOTAL_BITS-1:0] shreg_q;
  logic [TOTAL_BITS-1:0] snap_q;
  logic [CNT_W-1:0]      nbits_q;
  logic [15:0]           cyc_q;
  logic                  rdy_q, tmo_q;
  logic                  full, take_bit;

  assign full          = (nbits_q == CNT_W'(TOTAL_BITS));
  assign fill_active_o = enable_i && !rdy_q;
  assign take_bit      = fill_active_o && bit_vld_i && !full && !restart_i;
  assign fill_done_o   = fill_active_o && full && !restart_i && min_met(cyc_q, min_cyc_i);
  assign tmo_hit_o     = fill_active_o && !full && !restart_i && max_reached(cyc_q, max_cyc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      snap_q  <= '0;
      nbits_q <= '0;
      cyc_q   <= '0;
      rdy_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      if (restart_i || !enable_i) begin
        nbits_q <= '0;
        cyc_q   <= '0;
      end else if (fill_active_o) begin
        if (take_bit) begin
          shreg_q <= {shreg_q[TOTAL_BITS-2:0], bit_i};
          nbits_q <= nbits_q + CNT_W'(1);
        end
        cyc_q <= cyc_next(cyc_q);
      end

      if (restart_i) begin
        rdy_q <= 1'b0;
      end else if (fill_done_o) begin
        rdy_q  <= 1'b1;
        snap_q <= shreg_q;
      end

      if (tmo_hit_o)      tmo_q <= 1'b1;
      else if (clr_tmo_i) tmo_q <= 1'b0;
    end
  end

  assign words_o   = snap_q;
  assign ready_o   = rdy_q;
  assign tmo_o     = tmo_q;
  assign bit_cnt_o = nbits_q;
  assign cyc_cnt_o = cyc_q;

endmodule

// File: rtl/rwb_rdmux.sv
module rwb_rdmux
  import rwb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter logic [3:0]  REV_MAJOR = 4'd2,
  parameter logic [3:0]  REV_MINOR = 4'd3,
  parameter logic [3:0]  REV_PATCH = 4'd1,
  localparam int unsigned TOTAL_BITS = NUM_WORDS * WORD_W
) (
  input  logic [7:0]            addr_i,
  input  logic [TOTAL_BITS-1:0] words_i,
  input  logic                  ready_i,
  input  logic                  tmo_i,
  input  rwb_cfg_t              cfg_i,
  output logic [31:0]           rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_STATUS)    rdata_o = status_word(ready_i, tmo_i);
    else if (addr_i == OFS_CTRL) rdata_o = ctrl_word(cfg_i.enable);
    else if (addr_i == OFS_CFG)  rdata_o = cfg_word(cfg_i.max_cyc, cfg_i.min_cyc);
    else if (addr_i == OFS_REV)  rdata_o = rev_word(REV_MAJOR, REV_MINOR, REV_PATCH);
    else begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        if (addr_i == 8'(4 * k)) rdata_o = words_i[WORD_W*k +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/rand_word_buf.sv
module rand_word_buf
  import rwb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter logic [15:0] MAX_RST   = 16'hFFFF,
  parameter logic [7:0]  MIN_RST   = 8'h00,
  parameter logic [3:0]  REV_MAJOR = 4'd2,
  parameter logic [3:0]  REV_MINOR = 4'd3,
  parameter logic [3:0]  REV_PATCH = 4'd1,
  localparam int unsigned TOTAL_BITS = NUM_WORDS * WORD_W,
  localparam int unsigned CNT_W = $clog2(TOTAL_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rnd_bit_vld,
  input  logic                  rnd_bit,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [TOTAL_BITS-1:0] words_o,
  output logic                  ready_o
);

  rwb_cfg_t         cfg;
  logic             ack_ready, clr_tmo;
  logic             tmo_flag, fill_active, fill_done, tmo_hit;
  logic [CNT_W-1:0] bit_cnt;
  logic [15:0]      cyc_cnt;

  rwb_csr #(.MAX_RST(MAX_RST), .MIN_RST(MIN_RST)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (bus_wr),
    .addr_i      (bus_addr),
    .wdata_i     (bus_wdata),
    .cfg_o       (cfg),
    .ack_ready_o (ack_ready),
    .clr_tmo_o   (clr_tmo)
  );

  rwb_gather #(.TOTAL_BITS(TOTAL_BITS)) u_gather (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (cfg.enable),
    .restart_i     (ack_ready),
    .clr_tmo_i     (clr_tmo),
    .max_cyc_i     (cfg.max_cyc),
    .min_cyc_i     (cfg.min_cyc),
    .bit_vld_i     (rnd_bit_vld),
    .bit_i         (rnd_bit),
    .words_o       (words_o),
    .ready_o       (ready_o),
    .tmo_o         (tmo_flag),
    .fill_active_o (fill_active),
    .fill_done_o   (fill_done),
    .tmo_hit_o     (tmo_hit),
    .bit_cnt_o     (bit_cnt),
    .cyc_cnt_o     (cyc_cnt)
  );

  rwb_rdmux #(
    .NUM_WORDS (NUM_WORDS),
    .REV_MAJOR (REV_MAJOR),
    .REV_MINOR (REV_MINOR),
    .REV_PATCH (REV_PATCH)
  ) u_rdmux (
    .addr_i  (bus_addr),
    .words_i (words_o),
    .ready_i (ready_o),
    .tmo_i   (tmo_flag),
    .cfg_i   (cfg),
    .rdata_o (bus_rdata)
  );

endmodule

// File: rtl/rwb_checks.sv
module rwb_checks
  import rwb_pkg::*;
#(
  parameter int unsigned TOTAL_BITS = 128,
  localparam int unsigned CNT_W = $clog2(TOTAL_BITS + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [7:0]            bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  ready_o,
  input logic [TOTAL_BITS-1:0] words_o,
  input logic                  enable,
  input logic [CNT_W-1:0]      bit_cnt,
  input logic [15:0]           cyc_cnt,
  input logic [7:0]            min_cyc,
  input logic                  tmo_flag,
  input logic                  tmo_hit
);

  logic st_wr;
  assign st_wr = bus_wr && (bus_addr == OFS_STATUS);

  p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata[ST_READY_BIT]) |=> !ready_o);

  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(enable));

  p_full_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(bit_cnt) == CNT_W'(TOTAL_BITS)));

  p_min_cycles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(cyc_cnt) >= {8'h00, $past(min_cyc)}));

  p_words_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> (!ready_o || $stable(words_o)));

  p_tmo_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> tmo_flag);

  p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !(st_wr && bus_wdata[ST_TMO_BIT])) |=> tmo_flag);

endmodule

bind rand_word_buf rwb_checks #(.TOTAL_BITS(TOTAL_BITS)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ready_o   (ready_o),
  .words_o   (words_o),
  .enable    (cfg.enable),
  .bit_cnt   (bit_cnt),
  .cyc_cnt   (cyc_cnt),
  .min_cyc   (cfg.min_cyc),
  .tmo_flag  (tmo_flag),
  .tmo_hit   (tmo_hit)
);

// File: tb/tb_rand_word_buf.sv
module tb_rand_word_buf;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rnd_bit_vld = 1'b0;
  logic         rnd_bit = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [31:0]  bus_wdata = 32'h0;
  logic [31:0]  bus_rdata;
  logic [127:0] words_o;
  logic         ready_o;

  int nchk = 0;
  int nerr = 0;
  logic [127:0] exp_q[$];
  logic [127:0] acc = '0;
  logic [31:0]  lf = 32'h1BAD_F00D;

  always #10 clk = ~clk;

  rand_word_buf dut (
    .clk(clk), .rst_n(rst_n), .rnd_bit_vld(rnd_bit_vld), .rnd_bit(rnd_bit),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .words_o(words_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata === e, tag, 128'(bus_rdata), 128'(e));
  endtask

  // driver: feeds n bits with 'gap' idle cycles after each; pushes expected block
  task automatic feed(input int n, input int gap, input bit push);
    for (int i = 0; i < n; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rnd_bit_vld = 1'b1;
      rnd_bit = lf[0];
      acc = {acc[126:0], lf[0]};
      @(negedge clk);
      rnd_bit_vld = 1'b0;
      if (push && i == n - 1) exp_q.push_back(acc);
      repeat (gap) @(negedge clk);
    end
    rnd_bit_vld = 1'b0;
  endtask

  // monitor: each rising ready must match the next expected block (R1)
  initial begin : monitor
    logic was;
    logic [127:0] e;
    was = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && ready_o && !was) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R4 unexpected ready", words_o, '0);
        end else begin
          e = exp_q.pop_front();
          chk(words_o === e, "R1 block words", words_o, e);
        end
      end
      was = ready_o;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic [127:0] snap;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(ready_o === 1'b0, "R9 ready after reset", 128'(ready_o), 128'(0));
    chk(words_o === '0, "R9 words after reset", words_o, '0);
    rd_chk(8'h10, 32'h0, "R9 status after reset");
    rd_chk(8'h14, 32'h0, "R9 control after reset");
    rd_chk(8'h18, 32'hFFFF_0000, "R5 config reset value");
    rd_chk(8'h7C, 32'h0231_0000, "R8 revision word");
    rd_chk(8'h40, 32'h0, "R8 unmapped offset");

    // R3 / R5 register layout
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk(8'h14, 32'h0000_0400, "R3 control readback");
    wr(8'h18, 32'h00FF_AB0A);
    rd_chk(8'h18, 32'h00FF_000A, "R5 config readback");

    // block 1: back-to-back bits
    feed(128, 0, 1'b1);
    repeat (2) @(negedge clk);
    chk(ready_o === 1'b1, "R4 ready after full block", 128'(ready_o), 128'(1));
    for (int k = 0; k < 4; k++) rd_chk(8'(4 * k), acc[32*k +: 32], "R1 word via bus");
    rd_chk(8'h10, 32'h1, "R7 no timeout within max");

    // R6 frozen while ready, R8 read-only write, R2 write of zero
    snap = acc;
    feed(40, 0, 1'b0);
    chk(words_o === snap, "R6 words frozen while ready", words_o, snap);
    wr(8'h00, 32'hDEAD_BEEF);
    rd_chk(8'h00, snap[31:0], "R8 write to data word ignored");
    wr(8'h10, 32'h0);
    chk(ready_o === 1'b1, "R2 write zero keeps ready", 128'(ready_o), 128'(1));

    // R2 acknowledge, then block 2 with gapped bits
    wr(8'h10, 32'h1);
    chk(ready_o === 1'b0, "R2 ack clears ready", 128'(ready_o), 128'(0));
    feed(128, 1, 1'b1);
    repeat (3) @(negedge clk);
    chk(ready_o === 1'b1, "R4 ready after gapped block", 128'(ready_o), 128'(1));

    // R4 minimum cycle floor of 200
    wr(8'h18, {16'h0FFF, 8'h00, 8'd200});
    wr(8'h10, 32'h1);
    feed(128, 0, 1'b1);
    chk(ready_o === 1'b0, "R4 min not met at 128 bits", 128'(ready_o), 128'(0));
    repeat (60) @(negedge clk);
    chk(ready_o === 1'b0, "R4 min not met at 188 cycles", 128'(ready_o), 128'(0));
    repeat (20) @(negedge clk);
    chk(ready_o === 1'b1, "R4 ready once min met", 128'(ready_o), 128'(1));

    // R7 timeout with max 50, gapped stream still completes
    wr(8'h18, {16'd50, 8'h00, 8'd0});
    wr(8'h10, 32'h1);
    feed(128, 1, 1'b1);
    repeat (3) @(negedge clk);
    rd_chk(8'h10, 32'h3, "R7 timeout set and block completes");
    wr(8'h10, 32'h2);
    rd_chk(8'h10, 32'h1, "R7 timeout cleared, ready kept");

    // R3 disabled: bits ignored, no ready
    wr(8'h18, {16'hFFFF, 8'h00, 8'd0});
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h1);
    feed(128, 0, 1'b0);
    repeat (20) @(negedge clk);
    chk(ready_o === 1'b0, "R3 no ready while disabled", 128'(ready_o), 128'(0));
    rd_chk(8'h10, 32'h0, "R3 status while disabled");
    wr(8'h14, 32'h0000_0400);
    feed(128, 0, 1'b1);
    repeat (3) @(negedge clk);
    chk(ready_o === 1'b1, "R3 ready after re-enable", 128'(ready_o), 128'(1));

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 every expected block seen", 128'(exp_q.size()), 128'(0));
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule